// File: doc/BRIEF.md
# Dual-Player Swing Pulse Selector

This block turns raw player push-buttons into one short swing indication for each press. It also lets a controller watch one chosen player through a selected output. Each player has its own path, made of two parts. The first part is a capture flop that a press sets without waiting for the clock. Every rising clock edge clears it while the button is up. The second part is a two-state tracker. It records that a press has already been reported, so a held button cannot produce a second indication.

A swing therefore rises as soon as the button goes down and falls after the next rising clock edge. It stays low for as long as the button is held. A new swing can come only after the button has been seen up at a clock edge. The controller picks a player with the select input. An active-high disable forces the selected output low. Debounce filtering is not part of the block; the buttons are assumed to be clean.

Top module: `swing_pulse_selector`

## Requirements
- R1: With the disable low, select value 0 drives `swing_sel_o` from player A (`swing_o[0]`) and select value 1 drives it from player B (`swing_o[1]`).
- R2: While `sel_off_i` is high, `swing_sel_o` is 0 whatever the select value and the button states.
- R3: A button held down across several rising clock edges gives one indication only; its swing output is 0 at every sample after the first edge of the hold.
- R4: A press raises that player's swing output in the same clock period, with no rising edge needed, and the output is 0 again after the next rising clock edge.
- R5: A press released again before the next rising edge still leaves the swing output high until that edge.
- R6: After a release, a new swing appears only if the button was up at a rising edge and was not pressed again before the rising edge that follows; a press made before that second edge is not reported.
- R7: After synchronous reset with all buttons up, every swing output and `swing_sel_o` is 0.
- R8: A press by one player leaves the other player's swing output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of both trackers |
| btn_i | input | N_PLAYERS | Raw button levels, 1 = pressed, bit 0 = player A |
| sel_i | input | SEL_W | Player chosen for the selected output |
| sel_off_i | input | 1 | Active-high disable of the selected output |
| swing_o | output | N_PLAYERS | Swing indication of each player |
| swing_sel_o | output | 1 | Swing indication of the chosen player, or 0 when disabled |

## Verification
The assertions assume that buttons, select and disable change only away from the rising clock edge. They also assume that a button level seen at two consecutive edges was held between them, with no extra release and press in that gap. The bench changes every input on the falling edge. It holds each button level for whole clock periods, except in the short-press case, which is released before the next rising edge. It sweeps player, select, disable, hold length and release gap for every combination.

// File: rtl/swing_pulse_pkg.sv
package swing_pulse_pkg;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_HELD = 1'b1
  } trk_state_t;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/swing_capture.sv
module swing_capture (
  input  logic clk,
  input  logic btn_i,
  output logic cap_o
);

  // The press sets the flop without waiting for the clock. Every rising edge
  // loads the idle value, unless the button is still holding the set input.
  always_ff @(posedge clk or posedge btn_i) begin
    if (btn_i) cap_o <= 1'b1;
    else       cap_o <= 1'b0;
  end

endmodule

// File: rtl/swing_tracker.sv
module swing_tracker
  import swing_pulse_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cap_i,
  output logic swing_o
);

  trk_state_t state_q;
  trk_state_t state_d;

  always_comb begin
    state_d = cap_i ? TRK_HELD : TRK_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= TRK_IDLE;
    else     state_q <= state_d;
  end

  // Mealy output: report the capture only while no press is recorded yet.
  assign swing_o = cap_i && (state_q == TRK_IDLE);

endmodule

// File: rtl/swing_select.sv
module swing_select #(
  parameter int N_PLAYERS = 2,
  parameter int SEL_W     = 1
) (
  input  logic [N_PLAYERS-1:0] swing_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 off_i,
  output logic                 swing_o
);

  always_comb begin
    swing_o = 1'b0;
    for (int k = 0; k < N_PLAYERS; k++) begin
      if (!off_i && (int'(sel_i) == k)) swing_o = swing_i[k];
    end
  end

endmodule

// File: rtl/swing_pulse_selector.sv
module swing_pulse_selector
  import swing_pulse_pkg::*;
#(
  parameter int N_PLAYERS = 2,
  localparam int SEL_W    = sel_width(N_PLAYERS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_PLAYERS-1:0] btn_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 sel_off_i,
  output logic [N_PLAYERS-1:0] swing_o,
  output logic                 swing_sel_o
);

  logic [N_PLAYERS-1:0] cap;

  for (genvar p = 0; p < N_PLAYERS; p++) begin : g_player
    swing_capture u_cap (
      .clk   (clk),
      .btn_i (btn_i[p]),
      .cap_o (cap[p])
    );

    swing_tracker u_trk (
      .clk     (clk),
      .rst     (rst),
      .cap_i   (cap[p]),
      .swing_o (swing_o[p])
    );
  end

  swing_select #(
    .N_PLAYERS (N_PLAYERS),
    .SEL_W     (SEL_W)
  ) u_sel (
    .swing_i (swing_o),
    .sel_i   (sel_i),
    .off_i   (sel_off_i),
    .swing_o (swing_sel_o)
  );

endmodule

// File: rtl/swing_pulse_selector_chk.sv
module swing_pulse_selector_chk #(
  parameter int N_PLAYERS = 2,
  parameter int SEL_W     = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_PLAYERS-1:0] btn_i,
  input logic [SEL_W-1:0]     sel_i,
  input logic                 sel_off_i,
  input logic [N_PLAYERS-1:0] swing_o,
  input logic                 swing_sel_o
);

  // R1: routing of player A and player B
  a_r1_route_a: assert property (@(posedge clk) disable iff (rst)
    (!sel_off_i && int'(sel_i) == 0) |-> (swing_sel_o == swing_o[0]));
  a_r1_route_b: assert property (@(posedge clk) disable iff (rst)
    (!sel_off_i && int'(sel_i) == 1) |-> (swing_sel_o == swing_o[1]));

  // R2: disable forces the selected output low
  a_r2_disable: assert property (@(posedge clk) disable iff (rst)
    sel_off_i |-> !swing_sel_o);

  for (genvar p = 0; p < N_PLAYERS; p++) begin : g_chk
    // R4: a swing never lasts past the next rising edge
    a_r4_one_edge: assert property (@(posedge clk) disable iff (rst)
      swing_o[p] |=> !swing_o[p]);

    // R3: a button seen down at two edges in a row gives no swing
    a_r3_held: assert property (@(posedge clk) disable iff (rst)
      (btn_i[p] && $past(btn_i[p]) && !$past(rst)) |-> !swing_o[p]);

    // R6: a swing needs the button up at the previous edge
    a_r6_release_seen: assert property (@(posedge clk) disable iff (rst)
      (swing_o[p] && !$past(rst)) |-> !$past(btn_i[p]));
  end

endmodule

bind swing_pulse_selector swing_pulse_selector_chk #(
  .N_PLAYERS (N_PLAYERS),
  .SEL_W     (SEL_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .btn_i       (btn_i),
  .sel_i       (sel_i),
  .sel_off_i   (sel_off_i),
  .swing_o     (swing_o),
  .swing_sel_o (swing_sel_o)
);

// File: tb/swing_pulse_selector_test.sv
module swing_pulse_selector_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] btn;
  logic          sel;
  logic          sel_off;
  logic [NP-1:0] swing;
  logic          swing_sel;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  swing_pulse_selector #(.N_PLAYERS(NP)) uut (
    .clk         (clk),
    .rst         (rst),
    .btn_i       (btn),
    .sel_i       (sel),
    .sel_off_i   (sel_off),
    .swing_o     (swing),
    .swing_sel_o (swing_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_sel(input int p, input logic s, input logic off,
                                   input logic own);
    if (off) return 1'b0;
    return (int'(s) == p) ? own : 1'b0;
  endfunction

  task automatic do_reset();
    btn = '0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check("R7 swing A after reset", swing[0], 1'b0);
    check("R7 swing B after reset", swing[1], 1'b0);
    check("R7 selected after reset", swing_sel, 1'b0);
  endtask

  task automatic scenario(input int p, input logic s, input logic off,
                          input int hold, input int gap);
    do_reset();
    sel = s;
    sel_off = off;
    @(negedge clk);
    btn[p] = 1'b1;
    #1;
    check("R4 swing rises on press", swing[p], 1'b1);
    check("R8 other player quiet", swing[1-p], 1'b0);
    if (off) check("R2 disabled output low", swing_sel, 1'b0);
    else     check("R1 routed output", swing_sel, exp_sel(p, s, off, 1'b1));
    @(negedge clk);
    #1;
    check("R4 swing falls after edge", swing[p], 1'b0);
    for (int k = 1; k < hold; k++) begin
      @(negedge clk);
      #1;
      check("R3 held button silent", swing[p], 1'b0);
      check("R3 held selected silent", swing_sel, 1'b0);
    end
    @(negedge clk);
    btn[p] = 1'b0;
    repeat (gap) @(negedge clk);
    btn[p] = 1'b1;
    #1;
    check("R6 repress after gap", swing[p], (gap >= 2) ? 1'b1 : 1'b0);
    check("R6 repress selected", swing_sel,
          exp_sel(p, s, off, (gap >= 2) ? 1'b1 : 1'b0));
    @(negedge clk);
    btn[p] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    btn = '0;
    sel = 1'b0;
    sel_off = 1'b0;
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < 2; s++)
        for (int off = 0; off < 2; off++)
          for (int hold = 1; hold <= 3; hold++)
            for (int gap = 1; gap <= 3; gap++)
              scenario(p, s[0], off[0], hold, gap);

    // R5: short press released before the next rising edge
    for (int p = 0; p < NP; p++) begin
      do_reset();
      sel = p[0];
      sel_off = 1'b0;
      @(negedge clk);
      btn[p] = 1'b1;
      #2;
      btn[p] = 1'b0;
      #1;
      check("R5 short press latched", swing[p], 1'b1);
      check("R5 short press selected", swing_sel, 1'b1);
      @(negedge clk);
      #1;
      check("R5 short press ends at edge", swing[p], 1'b0);
    end

    // R1: both players pressed, select picks the reported one
    for (int s = 0; s < 2; s++) begin
      do_reset();
      sel = s[0];
      sel_off = 1'b0;
      @(negedge clk);
      btn[0] = 1'b1;
      #1;
      check("R1 A pressed, B idle", swing_sel, (s == 0) ? 1'b1 : 1'b0);
      @(negedge clk);
      btn[0] = 1'b0;
      repeat (2) @(negedge clk);
      btn[1] = 1'b1;
      #1;
      check("R1 B pressed, A idle", swing_sel, (s == 1) ? 1'b1 : 1'b0);
      @(negedge clk);
      btn[1] = 1'b0;
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule